// File: doc/BRIEF.md
# Core Power Domain Sequencer

This block is the always-on power controller for a single processor core. Software on the core programs it through a small set of memory-mapped registers. The controller then takes the core logic domain down for one of two low-power states. In deep-off, the core domain and the RAM domain both lose power. In retention, the RAM domain stays powered and its inputs are clamped. A power-down request never completes until the core signals that it has reached its standby (wait-for-interrupt) state.

On the way down, the core is held in reset before its power switch opens. It stays in reset for the whole off period. On the way up, the controller closes the switch and waits for the power-good input. It then releases the RAM clamp and lets the core out of reset a fixed number of cycles later. A sticky status bit tells boot code whether it is coming back from retention and must restore saved state, or is starting cold.

The controller's own reset is the system reset. It always starts with a cold power-up sequence, and that sequence is the only way out of deep-off.

Top module: `core_pwr_seq`

## Requirements
- R1: The core power enable never falls unless the standby input was high two cycles earlier. A valid command written while standby is low stays pending, with power on, until standby rises.
- R2: On the way down, the core reset is asserted for at least one cycle before the core power enable falls.
- R3: Whenever the core power enable is low, the core reset is high. The core reset also stays high after power returns, until power-good has been seen.
- R4: In retention (command code 2), the RAM power enable stays high while the core is off, and the RAM clamp is high whenever the core is off.
- R5: In deep-off (command code 1), the core power enable and the RAM power enable are both low. A write to the wake register has no effect. Only the system reset leaves this state.
- R6: During wake-up, the RAM clamp falls in the cycle after power-good is sampled high. The core reset falls exactly 16 cycles after the clamp falls.
- R7: The command register is at byte offset 0. A write of 1 or 2 starts a sequence, but only while the controller is idle. Other values, and any write while busy, are ignored. A read returns the mode in progress, or 0 when idle.
- R8: The status register is at byte offset 4. Bit 0 is the restore flag: it is 0 after system reset and is set when the core is powered off in retention. Bit 1 is busy: it is high whenever the controller is not in the run state, including the cold power-up after reset.
- R9: Writing 1 to status bit 0 clears the restore flag. Writing 0 to it leaves the flag unchanged.
- R10: Any write to byte offset 8 while the core is off in retention starts the wake-up sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | System reset, active low |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from the address) |
| core_standby | input | 1 | Core is in standby (wait-for-interrupt) |
| core_pgood | input | 1 | Core domain supply is good |
| core_pwr_en | output | 1 | Core domain power switch enable |
| core_reset | output | 1 | Core reset, active high |
| ram_pwr_en | output | 1 | RAM domain power switch enable |
| ram_clamp | output | 1 | Clamp RAM inputs, chip enable held inactive |

## Verification
The assertions check the ordering rules on every cycle: power falls only after standby and after reset, reset is held whenever power is off, the clamp is held whenever the RAM is powered but the core is not, and reset is never released without power. The bench scenarios cover what depends on the sequence of events: a command held pending while standby is low, the exact 16-cycle gap between clamp release and reset release, the wake register being ignored in deep-off, rejected command codes, and the set and write-one-to-clear behaviour of the restore flag.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_PEND = 3'd1,
    ST_ASRT = 3'd2,
    ST_OFF  = 3'd3,
    ST_WAKE = 3'd4,
    ST_REL  = 3'd5
  } seq_state_t;

  localparam logic [1:0] MODE_NONE = 2'd0;
  localparam logic [1:0] MODE_DEEP = 2'd1;
  localparam logic [1:0] MODE_RETN = 2'd2;

  function automatic logic mode_ok(input logic [31:0] code);
    return (code == 32'd1) || (code == 32'd2);
  endfunction

  function automatic logic [31:0] status_word(input logic restore, input logic busy);
    return {30'd0, busy, restore};
  endfunction

endpackage

// File: rtl/pwr_dly_cnt.sv
module pwr_dly_cnt #(
  parameter int unsigned DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (!done)   cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  // R6
  dly_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run))
    else $error("delay done without a running window");
endmodule

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
  import pwr_seq_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          busy,
  input  logic [1:0]    cur_mode,
  input  logic          set_restore,
  output logic          cmd_go,
  output logic [1:0]    cmd_mode,
  output logic          wake_go,
  output logic          restore
);
  localparam logic [AW-1:0] A_CMD  = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(4);
  localparam logic [AW-1:0] A_WAKE = AW'(8);

  logic wr;
  logic clr_restore;

  assign wr          = bus_valid && bus_write;
  assign cmd_go      = wr && (bus_addr == A_CMD) && !busy && mode_ok(32'(bus_wdata));
  assign cmd_mode    = bus_wdata[1:0];
  assign wake_go     = wr && (bus_addr == A_WAKE);
  assign clr_restore = wr && (bus_addr == A_STAT) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           restore <= 1'b0;
    else if (set_restore) restore <= 1'b1;
    else if (clr_restore) restore <= 1'b0;
  end

  always_comb begin
    unique case (bus_addr)
      A_CMD:   bus_rdata = DW'(cur_mode);
      A_STAT:  bus_rdata = DW'(status_word(restore, busy));
      default: bus_rdata = '0;
    endcase
  end

  // R9
  restore_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_restore && !set_restore) |=> !restore)
    else $error("restore flag not cleared");
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned REL_DLY = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_go,
  input  logic [1:0] cmd_mode,
  input  logic       wake_go,
  input  logic       standby,
  input  logic       pgood,
  output logic       busy,
  output logic [1:0] cur_mode,
  output logic       set_restore,
  output logic       core_pwr_en,
  output logic       core_reset,
  output logic       ram_pwr_en,
  output logic       ram_clamp
);
  seq_state_t st_q, st_d;
  logic [1:0] mode_q;
  logic       rel_done;
  logic       enter_off;

  pwr_dly_cnt #(.DLY(REL_DLY)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_q == ST_REL),
    .done (rel_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (cmd_go) st_d = ST_PEND;
      ST_PEND: if (standby) st_d = ST_ASRT;
      ST_ASRT: st_d = ST_OFF;
      ST_OFF:  if (wake_go && mode_q == MODE_RETN) st_d = ST_WAKE;
      ST_WAKE: if (pgood) st_d = ST_REL;
      ST_REL:  if (rel_done) st_d = ST_RUN;
      default: st_d = ST_WAKE;
    endcase
  end

  assign enter_off = (st_q == ST_ASRT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_WAKE;
      mode_q <= MODE_NONE;
    end else begin
      st_q <= st_d;
      if (st_q == ST_RUN && cmd_go) mode_q <= cmd_mode;
      else if (st_d == ST_RUN)      mode_q <= MODE_NONE;
    end
  end

  assign busy        = (st_q != ST_RUN);
  assign cur_mode    = mode_q;
  assign set_restore = enter_off && (mode_q == MODE_RETN);
  assign core_pwr_en = (st_q != ST_OFF);
  assign core_reset  = (st_q == ST_ASRT) || (st_q == ST_OFF) ||
                       (st_q == ST_WAKE) || (st_q == ST_REL);
  assign ram_clamp   = (st_q == ST_ASRT) || (st_q == ST_OFF) || (st_q == ST_WAKE);
  assign ram_pwr_en  = !((st_q == ST_OFF) && (mode_q == MODE_DEEP));

  // R1
  standby_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_pwr_en) |-> $past(standby, 2))
    else $error("power removed without standby");
  // R2
  reset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_pwr_en) |-> $past(core_reset))
    else $error("power removed before reset");
  // R3
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pwr_en |-> core_reset)
    else $error("reset released while unpowered");
  // R4
  clamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_pwr_en && ram_pwr_en) |-> ram_clamp)
    else $error("RAM unclamped with core off");
  // R6
  release_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_reset) |-> (core_pwr_en && !ram_clamp))
    else $error("reset released in a bad state");
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned AW      = 4,
  parameter int unsigned DW      = 32,
  parameter int unsigned REL_DLY = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          core_standby,
  input  logic          core_pgood,
  output logic          core_pwr_en,
  output logic          core_reset,
  output logic          ram_pwr_en,
  output logic          ram_clamp
);
  logic       busy, cmd_go, wake_go, restore, set_restore;
  logic [1:0] cmd_mode, cur_mode;

  pwr_seq_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .cur_mode   (cur_mode),
    .set_restore(set_restore),
    .cmd_go     (cmd_go),
    .cmd_mode   (cmd_mode),
    .wake_go    (wake_go),
    .restore    (restore)
  );

  pwr_seq_fsm #(.REL_DLY(REL_DLY)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_go     (cmd_go),
    .cmd_mode   (cmd_mode),
    .wake_go    (wake_go),
    .standby    (core_standby),
    .pgood      (core_pgood),
    .busy       (busy),
    .cur_mode   (cur_mode),
    .set_restore(set_restore),
    .core_pwr_en(core_pwr_en),
    .core_reset (core_reset),
    .ram_pwr_en (ram_pwr_en),
    .ram_clamp  (ram_clamp)
  );

  // R8
  restore_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_pwr_en && ram_pwr_en) |-> restore)
    else $error("retention off without restore flag");
  // R5
  deep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_pwr_en) |-> (!core_pwr_en && core_reset))
    else $error("RAM off while core powered");
endmodule

// File: tb/core_pwr_seq_bench.sv
module core_pwr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        core_standby = 1'b0, core_pgood = 1'b0;
  logic        core_pwr_en, core_reset, ram_pwr_en, ram_clamp;

  always #2 clk = ~clk;

  core_pwr_seq u_core_pwr_seq (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_standby(core_standby), .core_pgood(core_pgood),
    .core_pwr_en(core_pwr_en), .core_reset(core_reset),
    .ram_pwr_en(ram_pwr_en), .ram_clamp(ram_clamp)
  );

  typedef struct { string req; logic [31:0] act; logic [31:0] exp; } item_t;
  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    item_t it;
    it.req = req; it.act = act; it.exp = exp;
    sb_q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (it.act !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=%0h expected=%0h", it.req, it.act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic boot_measure(input string req);
    int hold = 0;
    core_pgood = 1;
    while (ram_clamp) @(negedge clk);
    while (core_reset) begin hold++; @(negedge clk); end
    expect_eq(req, 32'(hold), 32'd16);
  endtask

  initial begin : stim
    logic [31:0] d;
    int k;
    idle(3); rst_n = 1; idle(2);
    // R8 R3 reset state: cold power-up held in reset, busy, no restore
    expect_eq("R3 reset held at cold start", {core_pwr_en, core_reset, ram_clamp, ram_pwr_en}, 32'hF);
    rd(4'd4, d); expect_eq("R8 status after reset", d, 32'h2);
    idle(5);
    expect_eq("R3 reset held without pgood", core_reset, 1);
    // R6 cold boot release timing
    boot_measure("R6 clamp-to-reset gap (cold)");
    rd(4'd4, d); expect_eq("R8 status idle cold", d, 32'h0);
    // R7 invalid code ignored
    wr(4'd0, 32'd3); idle(2);
    rd(4'd4, d); expect_eq("R7 code 3 ignored", d, 32'h0);
    // R1 pending without standby
    wr(4'd0, 32'd2); idle(20);
    expect_eq("R1 power kept without standby", core_pwr_en, 1);
    rd(4'd0, d); expect_eq("R7 mode readback", d, 32'd2);
    rd(4'd4, d); expect_eq("R8 busy while pending", d, 32'h2);
    wr(4'd0, 32'd1);
    rd(4'd0, d); expect_eq("R7 write while busy ignored", d, 32'd2);
    // R2 reset before power drop
    core_standby = 1;
    k = 0;
    while (!core_reset) begin k++; @(negedge clk); end
    expect_eq("R2 reset before power off", core_pwr_en, 1);
    @(negedge clk);
    expect_eq("R2 power off after reset", {core_pwr_en, core_reset}, 32'h1);
    core_pgood = 0; core_standby = 0;
    // R4 retention off
    expect_eq("R4 ram powered and clamped", {ram_pwr_en, ram_clamp}, 32'h3);
    rd(4'd4, d); expect_eq("R8 restore set in retention", d, 32'h3);
    // R10 wake
    wr(4'd8, 32'd0); idle(2);
    expect_eq("R10 power back on", core_pwr_en, 1);
    idle(8);
    expect_eq("R3 reset held until pgood", {core_reset, ram_clamp}, 32'h3);
    boot_measure("R6 clamp-to-reset gap (wake)");
    rd(4'd4, d); expect_eq("R8 restore after wake", d, 32'h1);
    // R9 write-one-to-clear
    wr(4'd4, 32'd0);
    rd(4'd4, d); expect_eq("R9 write 0 keeps flag", d, 32'h1);
    wr(4'd4, 32'd1);
    rd(4'd4, d); expect_eq("R9 write 1 clears flag", d, 32'h0);
    // R5 deep-off
    core_standby = 1;
    wr(4'd0, 32'd1); idle(4);
    core_pgood = 0;
    expect_eq("R5 both domains off", {core_pwr_en, ram_pwr_en, core_reset}, 32'h1);
    rd(4'd4, d); expect_eq("R8 no restore in deep-off", d, 32'h2);
    wr(4'd8, 32'd1); idle(20);
    expect_eq("R5 wake ignored in deep-off", {core_pwr_en, ram_pwr_en}, 32'h0);
    core_standby = 0;
    rst_n = 0; idle(2); rst_n = 1; idle(1);
    expect_eq("R5 reset restarts power", {core_pwr_en, ram_pwr_en, core_reset}, 32'h7);
    boot_measure("R6 gap after deep-off");
    rd(4'd4, d); expect_eq("R8 cold status after deep-off", d, 32'h0);
    idle(2);
    done = 1;
  end

  initial begin : finish_ctl
    int cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule